// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the write side of a parallel NOR-flash style interface and turns sequences of bus writes into single-cycle operation requests. It samples the write-enable and chip-enable strobes (both active low, already synchronous to the block clock) and forms one bus write from each period in which both are low. The address is captured when that period begins and the data while it lasts. Every write is then matched against the unlock-and-command grammar. When a sequence completes, the block raises a one-cycle request carrying the operation code, the target bank and sector and, for a program, the address and data.

The decoder also keeps the mode state that changes how later writes are read. It tracks whether autoselect or the query mode is active, whether the secure region is open and whether unlock bypass is on, and it keeps one suspend flag per bank. The flash array, its timing and its erase algorithms are left to the surrounding logic. That logic reports which banks are running a sector erase through `erasing_i`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The address of a bus write is taken in the first clock cycle in which both strobes are low. The data is taken in the last such cycle, before either strobe returns high. Each bus write yields at most one request, and `op_valid_o` is high during the second clock cycle after the write ends.
- R2: In word mode (`byte_mode_i`=0) the two unlock writes are AAh to address 555h and then 55h to 2AAh, matched on address bits 10..0. In byte mode the first unlock write goes to AAAh and the second to 555h, matched on bits 11..0. Address bits above the match field and data bits 15..8 are ignored on command writes.
- R3: Unlock, unlock, A0h to the first unlock address, then any write gives a program request (code 1). `prog_addr_o` holds the raw address and `prog_data_o` the full 16-bit data of the fourth write.
- R4: Unlock, unlock, 80h, unlock, unlock, then a sixth write gives an erase request. A sixth write of 10h to the first unlock address gives a chip erase (code 2). A sixth write of 30h to any address gives a sector erase (code 3), with `sector_o` = word address bits 20..12 and `bank_o` = word address bits 20..18. The word address is `addr_i[20:0]` in word mode and `addr_i[21:1]` in byte mode.
- R5: Unlock, unlock, then 90h to the first unlock address enters autoselect (code 6). `autosel_o` goes high and `asel_bank_o` holds the bank of that third write. While autoselect is active, command sequences are ignored.
- R6: Unlock, unlock, 88h opens the secure region (code 7, `secure_o`=1). While it is open, unlock, unlock, 90h followed by 00h closes it (code 8). The 90h write does not enter autoselect.
- R7: Unlock, unlock, 20h enters bypass (code 11, `bypass_o`=1). In bypass, A0h followed by any write is a program request, and 90h followed by 00h leaves bypass (code 12). Unlock writes have no effect while bypass is on.
- R8: A single write of B0h requests a suspend (code 4) only when the bank of its address is erasing and not yet suspended; the write then sets that bank's bit in `suspended_o`. A single write of 30h requests a resume (code 5) only when the bank's bit is set, and the write clears the bit. In every other case neither write produces a request.
- R9: A write of F0h to any address, in any state, gives a reset request (code 10). It returns the sequence to idle and clears autoselect and query mode. It leaves `suspended_o`, bypass and the secure region unchanged.
- R10: A single write of 98h to 55h (word mode) or AAh (byte mode) enters query mode (code 9, `cfi_o`=1). This works only from read mode or from autoselect, and entering it clears autoselect. Writes other than F0h are ignored while query mode is active.
- R11: A write that does not fit the next step of a sequence returns the decoder to idle and produces no request.
- R12: After reset every output is zero. `op_o` reads 0 whenever `op_valid_o` is low, and `op_valid_o` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_ni | input | 1 | Write strobe, active low |
| ce_ni | input | 1 | Chip enable strobe, active low |
| addr_i | input | ADDR_W+1 | Bus address; bit 0 is the byte select in byte mode |
| data_i | input | DATA_W | Bus write data |
| byte_mode_i | input | 1 | 1 selects byte-mode unlock addresses |
| erasing_i | input | NUM_BANKS | Per-bank flag: a sector erase is running |
| op_valid_o | output | 1 | One-cycle request strobe |
| op_o | output | 4 | Operation code |
| prog_addr_o | output | ADDR_W+1 | Latched program address |
| prog_data_o | output | DATA_W | Latched program data |
| sector_o | output | SECT_W | Sector of the last request |
| bank_o | output | BANK_W | Bank of the last request |
| autosel_o | output | 1 | Autoselect mode active |
| asel_bank_o | output | BANK_W | Bank that entered autoselect |
| secure_o | output | 1 | Secure region open |
| bypass_o | output | 1 | Unlock bypass active |
| cfi_o | output | 1 | Query mode active |
| suspended_o | output | NUM_BANKS | Per-bank erase-suspended flags |

## Verification
The bench moves the address and data off their values while only one strobe is low and again once the first strobe rises. A decoder that latched at the wrong strobe edge would then report the wrong program address or data. It sends byte-mode writes to the word-mode unlock address and expects them to be ignored. It sends 90h while the secure region is open, F0h in the middle of an erase sequence, and B0h or 30h to banks that are not erasing or not suspended. Each of these would yield a spurious autoselect, erase, suspend or resume request if the gating were missing. Unlock writes during bypass, autoselect or query mode must stay silent, and so must the write that follows a broken sequence. Random program and erase sequences in both bus modes, with random upper address and data bits, check the sector and bank extraction.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [3:0] {
    OP_NONE       = 4'd0,
    OP_PROG       = 4'd1,
    OP_CHIP_ERASE = 4'd2,
    OP_SECT_ERASE = 4'd3,
    OP_SUSPEND    = 4'd4,
    OP_RESUME     = 4'd5,
    OP_AUTOSEL    = 4'd6,
    OP_SEC_ENTER  = 4'd7,
    OP_SEC_EXIT   = 4'd8,
    OP_CFI        = 4'd9,
    OP_RESET      = 4'd10,
    OP_BYP_ENTER  = 4'd11,
    OP_BYP_EXIT   = 4'd12
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PROG, ST_E0, ST_E1, ST_E2, ST_SECX, ST_BYPX
  } st_e;

  localparam logic [7:0] CMD_UNLK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B = 8'h55;
  localparam logic [7:0] CMD_ASEL   = 8'h90;
  localparam logic [7:0] CMD_SEC    = 8'h88;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_BYP    = 8'h20;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RST    = 8'hF0;
  localparam logic [7:0] CMD_CFI    = 8'h98;
  localparam logic [7:0] CMD_EXIT   = 8'h00;
endpackage

// File: rtl/fcd_strobe.sv
module fcd_strobe #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_ni,
  input  logic          ce_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          cyc_v_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          act, act_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign act = ~we_ni & ~ce_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act;
      if (act && !act_q) addr_q <= addr_i; // later falling strobe
      if (act) data_q <= data_i;           // last value before earlier rise
    end
  end

  assign cyc_v_o = act_q & ~act;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
endmodule

// File: rtl/fcd_classify.sv
module fcd_classify #(
  parameter int ADDR_W   = 21,
  parameter int BANK_LSB = 18,
  parameter int SECT_LSB = 12,
  localparam int BANK_W  = ADDR_W - BANK_LSB,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic [ADDR_W:0]   addr_i,
  input  logic              byte_mode_i,
  output logic              key1_o,
  output logic              key2_o,
  output logic              cfi_key_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [SECT_W-1:0] sector_o
);
  logic [ADDR_W-1:0] wa;

  assign wa = byte_mode_i ? addr_i[ADDR_W:1] : addr_i[ADDR_W-1:0];

  always_comb begin
    if (byte_mode_i) begin
      key1_o    = addr_i[11:0] == 12'hAAA;
      key2_o    = addr_i[11:0] == 12'h555;
      cfi_key_o = addr_i[11:0] == 12'h0AA;
    end else begin
      key1_o    = addr_i[10:0] == 11'h555;
      key2_o    = addr_i[10:0] == 11'h2AA;
      cfi_key_o = addr_i[10:0] == 11'h055;
    end
  end

  assign bank_o   = wa[ADDR_W-1:BANK_LSB];
  assign sector_o = wa[ADDR_W-1:SECT_LSB];
endmodule

// File: rtl/fcd_fsm.sv
module fcd_fsm import fcd_pkg::*; #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int BANK_W = 3,
  parameter int SECT_W = 9,
  localparam int NB    = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_v_i,
  input  logic [ADDR_W:0]   addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              key1_i,
  input  logic              key2_i,
  input  logic              cfi_key_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [SECT_W-1:0] sector_i,
  input  logic [NB-1:0]     erasing_i,
  output logic              op_valid_o,
  output logic [3:0]        op_o,
  output logic [ADDR_W:0]   prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic [SECT_W-1:0] sector_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              autosel_o,
  output logic [BANK_W-1:0] asel_bank_o,
  output logic              secure_o,
  output logic              bypass_o,
  output logic              cfi_o,
  output logic [NB-1:0]     suspended_o
);
  st_e               st_q, st_n;
  op_e               op_q, op_n;
  logic              opv_q;
  logic              asel_q, asel_n, cfi_q, cfi_n, sec_q, sec_n, byp_q, byp_n;
  logic [NB-1:0]     susp_q, susp_n;
  logic [BANK_W-1:0] asb_q, asb_n, bank_q;
  logic [SECT_W-1:0] sect_q;
  logic [ADDR_W:0]   pa_q;
  logic [DATA_W-1:0] pd_q;
  logic [7:0]        cmd;

  assign cmd = data_i[7:0];

  always_comb begin
    st_n   = st_q;
    op_n   = OP_NONE;
    asel_n = asel_q;
    cfi_n  = cfi_q;
    sec_n  = sec_q;
    byp_n  = byp_q;
    susp_n = susp_q;
    asb_n  = asb_q;
    if (cyc_v_i) begin
      if (cmd == CMD_RST) begin
        op_n   = OP_RESET;
        st_n   = ST_IDLE;
        asel_n = 1'b0;
        cfi_n  = 1'b0;
      end else if (cfi_q) begin
        st_n = ST_IDLE;
      end else if (asel_q) begin
        st_n = ST_IDLE;
        if (cmd == CMD_CFI && cfi_key_i) begin
          op_n   = OP_CFI;
          cfi_n  = 1'b1;
          asel_n = 1'b0;
        end
      end else begin
        st_n = ST_IDLE;
        unique case (st_q)
          ST_IDLE: begin
            if (cmd == CMD_SUSP) begin
              if (erasing_i[bank_i] && !susp_q[bank_i]) begin
                op_n           = OP_SUSPEND;
                susp_n[bank_i] = 1'b1;
              end
            end else if (cmd == CMD_SECT) begin
              if (susp_q[bank_i]) begin
                op_n           = OP_RESUME;
                susp_n[bank_i] = 1'b0;
              end
            end else if (byp_q) begin
              if (cmd == CMD_PROG)      st_n = ST_PROG;
              else if (cmd == CMD_ASEL) st_n = ST_BYPX;
            end else if (cmd == CMD_UNLK_A && key1_i) begin
              st_n = ST_U1;
            end else if (cmd == CMD_CFI && cfi_key_i && !sec_q) begin
              op_n  = OP_CFI;
              cfi_n = 1'b1;
            end
          end
          ST_U1: if (cmd == CMD_UNLK_B && key2_i) st_n = ST_U2;
          ST_U2: begin
            if (key1_i) begin
              unique case (cmd)
                CMD_ASEL: begin
                  if (sec_q) st_n = ST_SECX;
                  else begin
                    op_n   = OP_AUTOSEL;
                    asel_n = 1'b1;
                    asb_n  = bank_i;
                  end
                end
                CMD_SEC: begin
                  op_n  = OP_SEC_ENTER;
                  sec_n = 1'b1;
                end
                CMD_PROG:  st_n = ST_PROG;
                CMD_ERASE: st_n = ST_E0;
                CMD_BYP: begin
                  op_n  = OP_BYP_ENTER;
                  byp_n = 1'b1;
                end
                default: st_n = ST_IDLE;
              endcase
            end
          end
          ST_PROG: op_n = OP_PROG;
          ST_E0:   if (cmd == CMD_UNLK_A && key1_i) st_n = ST_E1;
          ST_E1:   if (cmd == CMD_UNLK_B && key2_i) st_n = ST_E2;
          ST_E2: begin
            if (cmd == CMD_CHIP && key1_i) op_n = OP_CHIP_ERASE;
            else if (cmd == CMD_SECT)      op_n = OP_SECT_ERASE;
          end
          ST_SECX: if (cmd == CMD_EXIT) begin
            op_n  = OP_SEC_EXIT;
            sec_n = 1'b0;
          end
          ST_BYPX: if (cmd == CMD_EXIT) begin
            op_n  = OP_BYP_EXIT;
            byp_n = 1'b0;
          end
          default: st_n = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_NONE;
      opv_q  <= 1'b0;
      asel_q <= 1'b0;
      cfi_q  <= 1'b0;
      sec_q  <= 1'b0;
      byp_q  <= 1'b0;
      susp_q <= '0;
      asb_q  <= '0;
      bank_q <= '0;
      sect_q <= '0;
      pa_q   <= '0;
      pd_q   <= '0;
    end else begin
      st_q   <= st_n;
      op_q   <= op_n;
      opv_q  <= op_n != OP_NONE;
      asel_q <= asel_n;
      cfi_q  <= cfi_n;
      sec_q  <= sec_n;
      byp_q  <= byp_n;
      susp_q <= susp_n;
      asb_q  <= asb_n;
      if (op_n != OP_NONE) begin
        bank_q <= bank_i;
        sect_q <= sector_i;
      end
      if (op_n == OP_PROG) begin
        pa_q <= addr_i;
        pd_q <= data_i;
      end
    end
  end

  assign op_valid_o  = opv_q;
  assign op_o        = op_q;
  assign prog_addr_o = pa_q;
  assign prog_data_o = pd_q;
  assign sector_o    = sect_q;
  assign bank_o      = bank_q;
  assign autosel_o   = asel_q;
  assign asel_bank_o = asb_q;
  assign secure_o    = sec_q;
  assign bypass_o    = byp_q;
  assign cfi_o       = cfi_q;
  assign suspended_o = susp_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 16,
  parameter int BANK_LSB  = 18,
  parameter int SECT_LSB  = 12,
  localparam int BANK_W   = ADDR_W - BANK_LSB,
  localparam int SECT_W   = ADDR_W - SECT_LSB,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_ni,
  input  logic                 ce_ni,
  input  logic [ADDR_W:0]      addr_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic                 byte_mode_i,
  input  logic [NUM_BANKS-1:0] erasing_i,
  output logic                 op_valid_o,
  output logic [3:0]           op_o,
  output logic [ADDR_W:0]      prog_addr_o,
  output logic [DATA_W-1:0]    prog_data_o,
  output logic [SECT_W-1:0]    sector_o,
  output logic [BANK_W-1:0]    bank_o,
  output logic                 autosel_o,
  output logic [BANK_W-1:0]    asel_bank_o,
  output logic                 secure_o,
  output logic                 bypass_o,
  output logic                 cfi_o,
  output logic [NUM_BANKS-1:0] suspended_o
);
  logic              cyc_v;
  logic [ADDR_W:0]   cyc_addr;
  logic [DATA_W-1:0] cyc_data;
  logic              key1, key2, cfi_key;
  logic [BANK_W-1:0] cyc_bank;
  logic [SECT_W-1:0] cyc_sect;

  fcd_strobe #(.AW(ADDR_W + 1), .DW(DATA_W)) u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_ni   (we_ni),
    .ce_ni   (ce_ni),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .cyc_v_o (cyc_v),
    .addr_o  (cyc_addr),
    .data_o  (cyc_data)
  );

  fcd_classify #(.ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB), .SECT_LSB(SECT_LSB)) u_classify (
    .addr_i      (cyc_addr),
    .byte_mode_i (byte_mode_i),
    .key1_o      (key1),
    .key2_o      (key2),
    .cfi_key_o   (cfi_key),
    .bank_o      (cyc_bank),
    .sector_o    (cyc_sect)
  );

  fcd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .SECT_W(SECT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cyc_v_i     (cyc_v),
    .addr_i      (cyc_addr),
    .data_i      (cyc_data),
    .key1_i      (key1),
    .key2_i      (key2),
    .cfi_key_i   (cfi_key),
    .bank_i      (cyc_bank),
    .sector_i    (cyc_sect),
    .erasing_i   (erasing_i),
    .op_valid_o  (op_valid_o),
    .op_o        (op_o),
    .prog_addr_o (prog_addr_o),
    .prog_data_o (prog_data_o),
    .sector_o    (sector_o),
    .bank_o      (bank_o),
    .autosel_o   (autosel_o),
    .asel_bank_o (asel_bank_o),
    .secure_o    (secure_o),
    .bypass_o    (bypass_o),
    .cfi_o       (cfi_o),
    .suspended_o (suspended_o)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker import fcd_pkg::*; #(
  parameter int NB = 8,
  parameter int BW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NB-1:0] erasing_i,
  input logic          op_valid_o,
  input logic [3:0]    op_o,
  input logic [BW-1:0] bank_o,
  input logic          autosel_o,
  input logic          secure_o,
  input logic          bypass_o,
  input logic          cfi_o,
  input logic [NB-1:0] suspended_o
);
  logic [NB-1:0] ers_q, susp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ers_q  <= '0;
      susp_q <= '0;
    end else begin
      ers_q  <= erasing_i;
      susp_q <= suspended_o;
    end
  end

  p_single_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |=> !op_valid_o);

  p_none_when_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_o |-> op_o == 4'(OP_NONE));

  p_suspend_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_o == 4'(OP_SUSPEND)) |->
      (ers_q[bank_o] && !susp_q[bank_o] && suspended_o[bank_o]));

  p_resume_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_o == 4'(OP_RESUME)) |-> (susp_q[bank_o] && !suspended_o[bank_o]));

  p_reset_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_o == 4'(OP_RESET)) |-> (!autosel_o && !cfi_o && suspended_o == susp_q));

  p_autosel_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_o == 4'(OP_AUTOSEL)) |-> autosel_o);

  p_secure_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_o == 4'(OP_SEC_ENTER)) |-> secure_o);

  p_bypass_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_o == 4'(OP_BYP_EXIT)) |-> !bypass_o);

  p_modes_exclusive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfi_o && autosel_o));
endmodule

bind flash_cmd_decoder fcd_checker #(.NB(NUM_BANKS), .BW(BANK_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .erasing_i   (erasing_i),
  .op_valid_o  (op_valid_o),
  .op_o        (op_o),
  .bank_o      (bank_o),
  .autosel_o   (autosel_o),
  .secure_o    (secure_o),
  .bypass_o    (bypass_o),
  .cfi_o       (cfi_o),
  .suspended_o (suspended_o)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  import fcd_pkg::*;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int NB = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, we_n, ce_n, byte_m;
  logic [AW:0]   addr;
  logic [DW-1:0] data;
  logic [NB-1:0] ers;

  logic          op_valid, autosel, secure, bypass, cfi;
  logic [3:0]    op;
  logic [AW:0]   pa;
  logic [DW-1:0] pd;
  logic [8:0]    sect;
  logic [2:0]    bank, asb;
  logic [NB-1:0] susp;

  flash_cmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_ni(we_n), .ce_ni(ce_n), .addr_i(addr), .data_i(data),
    .byte_mode_i(byte_m), .erasing_i(ers), .op_valid_o(op_valid), .op_o(op),
    .prog_addr_o(pa), .prog_data_o(pd), .sector_o(sect), .bank_o(bank),
    .autosel_o(autosel), .asel_bank_o(asb), .secure_o(secure), .bypass_o(bypass),
    .cfi_o(cfi), .suspended_o(susp)
  );

  int checks = 0;
  int fails  = 0;

  logic          g_v;
  logic [3:0]    g_op;
  logic [AW:0]   g_pa;
  logic [DW-1:0] g_pd;
  logic [8:0]    g_sect;
  logic [2:0]    g_bank;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW:0] rnd();
    return (AW+1)'($urandom);
  endfunction

  function automatic logic [15:0] hd(input logic [7:0] c);
    return {8'($urandom), c};
  endfunction

  function automatic logic [AW:0] kaddr(input logic [11:0] k, input bit bm);
    logic [AW:0] r = rnd();
    return bm ? {r[AW:12], k} : {r[AW:11], k[10:0]};
  endfunction

  function automatic logic [11:0] k1(input bit bm); return bm ? 12'hAAA : 12'h555; endfunction
  function automatic logic [11:0] k2(input bit bm); return bm ? 12'h555 : 12'h2AA; endfunction
  function automatic logic [11:0] kc(input bit bm); return bm ? 12'h0AA : 12'h055; endfunction

  function automatic logic [AW-1:0] waddr(input logic [AW:0] a, input bit bm);
    return bm ? a[AW:1] : a[AW-1:0];
  endfunction

  function automatic logic [AW:0] bank_addr(input logic [2:0] b);
    logic [AW:0] r = rnd();
    return {1'b0, b, r[17:0]};
  endfunction

  // one bus write, address and data disturbed outside the latch windows
  task automatic wr(input logic [AW:0] a, input logic [15:0] d);
    bit cef = 1'($urandom);
    @(negedge clk);
    if (cef) ce_n = 1'b0; else we_n = 1'b0;
    addr = rnd(); data = 16'($urandom);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = a; data = d;
    @(negedge clk);
    addr = rnd();
    @(negedge clk);
    if (cef) we_n = 1'b1; else ce_n = 1'b1;
    data = 16'($urandom); addr = rnd();
    @(negedge clk);
    g_v = op_valid; g_op = op; g_pa = pa; g_pd = pd; g_sect = sect; g_bank = bank;
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wr_none(input string req, input logic [AW:0] a, input logic [15:0] d);
    wr(a, d);
    chk(req, {31'd0, g_v}, 32'd0);
  endtask

  task automatic wr_op(input string req, input logic [AW:0] a, input logic [15:0] d, input op_e e);
    wr(a, d);
    chk(req, {31'd0, g_v}, 32'd1);
    chk(req, {28'd0, g_op}, {28'd0, 4'(e)});
  endtask

  task automatic unlock(input string req);
    wr_none(req, kaddr(k1(byte_m), byte_m), hd(8'hAA));
    wr_none(req, kaddr(k2(byte_m), byte_m), hd(8'h55));
  endtask

  task automatic do_prog(input string req, input logic [AW:0] a, input logic [15:0] d);
    unlock(req);
    wr_none(req, kaddr(k1(byte_m), byte_m), hd(8'hA0));
    wr_op(req, a, d, OP_PROG);
    chk({req, "_R1_addr"}, 32'(g_pa), 32'(a));
    chk({req, "_R1_data"}, 32'(g_pd), 32'(d));
  endtask

  task automatic do_erase(input string req, input bit chip, input logic [AW:0] sa);
    logic [AW-1:0] wa;
    logic [AW:0]   last;
    unlock(req);
    wr_none(req, kaddr(k1(byte_m), byte_m), hd(8'h80));
    unlock(req);
    last = chip ? kaddr(k1(byte_m), byte_m) : sa;
    wa = waddr(last, byte_m);
    if (chip) wr_op(req, last, hd(8'h10), OP_CHIP_ERASE);
    else begin
      wr_op(req, last, hd(8'h30), OP_SECT_ERASE);
      chk({req, "_sector"}, 32'(g_sect), 32'(wa[AW-1:12]));
    end
    chk({req, "_bank"}, 32'(g_bank), 32'(wa[AW-1:18]));
  endtask

  logic [15:0] rd;
  logic [AW:0] ra;

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; we_n = 1'b1; ce_n = 1'b1; byte_m = 1'b0; ers = '0;
    addr = '0; data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R12_reset_valid", {31'd0, op_valid}, 32'd0);
    chk("R12_reset_op", {28'd0, op}, 32'd0);
    chk("R12_reset_modes", {27'd0, autosel, secure, bypass, cfi, 1'b0}, 32'd0);
    chk("R12_reset_susp", 32'(susp), 32'd0);

    // word and byte program
    do_prog("R3_word", rnd(), 16'h12C5);
    byte_m = 1'b1;
    do_prog("R2_byte", rnd(), 16'hBE3A);
    // word unlock address in byte mode is not an unlock
    wr_none("R2_wrongkey", kaddr(12'h555, 1'b1), hd(8'hAA));
    wr_none("R2_wrongkey", kaddr(12'h555, 1'b1), hd(8'h55));
    wr_none("R2_wrongkey", kaddr(12'hAAA, 1'b1), hd(8'hA0));
    wr_none("R2_wrongkey", rnd(), 16'h4321);
    byte_m = 1'b0;

    // erases
    do_erase("R4_sector_w", 1'b0, rnd());
    byte_m = 1'b1;
    do_erase("R4_chip_b", 1'b1, rnd());
    byte_m = 1'b0;
    unlock("R4_badchip");
    wr_none("R4_badchip", kaddr(k1(0), 0), hd(8'h80));
    unlock("R4_badchip");
    wr_none("R4_badchip", kaddr(12'h123, 0), hd(8'h10));

    // broken sequences
    unlock("R11_badcmd");
    wr_none("R11_badcmd", kaddr(k1(0), 0), hd(8'h77));
    wr_none("R11_after", rnd(), 16'h5A5A);
    wr_none("R11_badunlk", kaddr(k1(0), 0), hd(8'hAA));
    wr_none("R11_badunlk", kaddr(k2(0), 0), hd(8'h56));
    wr_none("R11_badunlk", kaddr(k1(0), 0), hd(8'hA0));
    wr_none("R11_badunlk", rnd(), 16'h0102);

    // autoselect, then query from autoselect, then reset
    unlock("R5_asel");
    ra = kaddr(k1(0), 0);
    wr_op("R5_asel", ra, hd(8'h90), OP_AUTOSEL);
    chk("R5_asel_flag", {31'd0, autosel}, 32'd1);
    chk("R5_asel_bank", 32'(asb), 32'(ra[20:18]));
    unlock("R5_asel_ignore");
    wr_none("R5_asel_ignore", kaddr(k1(0), 0), hd(8'hA0));
    wr_none("R5_asel_ignore", rnd(), 16'h7777);
    chk("R5_asel_hold", 32'(asb), 32'(ra[20:18]));
    wr_op("R10_cfi_from_asel", kaddr(kc(0), 0), hd(8'h98), OP_CFI);
    chk("R10_cfi_flag", {30'd0, cfi, autosel}, 32'd2);
    unlock("R10_cfi_ignore");
    wr_op("R9_reset", rnd(), hd(8'hF0), OP_RESET);
    chk("R9_reset_flags", {30'd0, cfi, autosel}, 32'd0);

    // query from read mode, wrong address first
    wr_none("R10_cfi_badaddr", kaddr(12'h0AA, 0), hd(8'h98));
    byte_m = 1'b1;
    wr_op("R10_cfi_byte", kaddr(kc(1), 1), hd(8'h98), OP_CFI);
    wr_op("R9_reset_cfi", rnd(), hd(8'hF0), OP_RESET);
    byte_m = 1'b0;

    // secure region
    unlock("R6_enter");
    wr_op("R6_enter", kaddr(k1(0), 0), hd(8'h88), OP_SEC_ENTER);
    chk("R6_flag", {31'd0, secure}, 32'd1);
    unlock("R6_exit");
    wr_none("R6_exit", kaddr(k1(0), 0), hd(8'h90));
    chk("R6_no_asel", {31'd0, autosel}, 32'd0);
    wr_op("R6_exit", rnd(), hd(8'h00), OP_SEC_EXIT);
    chk("R6_flag_off", {31'd0, secure}, 32'd0);

    // bypass
    unlock("R7_enter");
    wr_op("R7_enter", kaddr(k1(0), 0), hd(8'h20), OP_BYP_ENTER);
    chk("R7_flag", {31'd0, bypass}, 32'd1);
    wr_none("R7_prog", rnd(), hd(8'hA0));
    ra = rnd(); rd = 16'h9C3E;
    wr_op("R7_prog", ra, rd, OP_PROG);
    chk("R7_prog_addr", 32'(g_pa), 32'(ra));
    chk("R7_prog_data", 32'(g_pd), 32'(rd));
    unlock("R7_unlock_ignored");
    wr_none("R7_unlock_ignored", kaddr(k1(0), 0), hd(8'h88));
    chk("R7_no_secure", {31'd0, secure}, 32'd0);
    wr_none("R10_cfi_in_bypass", kaddr(kc(0), 0), hd(8'h98));
    chk("R10_cfi_in_bypass", {31'd0, cfi}, 32'd0);
    wr_none("R7_exit", rnd(), hd(8'h90));
    wr_op("R7_exit", rnd(), hd(8'h00), OP_BYP_EXIT);
    chk("R7_flag_off", {31'd0, bypass}, 32'd0);

    // suspend and resume
    wr_none("R8_not_erasing", bank_addr(3'd2), hd(8'hB0));
    chk("R8_not_erasing", 32'(susp), 32'd0);
    ers = 8'h04;
    wr_op("R8_suspend", bank_addr(3'd2), hd(8'hB0), OP_SUSPEND);
    chk("R8_suspend_bank", 32'(g_bank), 32'd2);
    chk("R8_suspend_flag", 32'(susp), 32'h04);
    wr_none("R8_double", bank_addr(3'd2), hd(8'hB0));
    wr_none("R8_resume_other", bank_addr(3'd5), hd(8'h30));
    wr_op("R9_reset_keeps", rnd(), hd(8'hF0), OP_RESET);
    chk("R9_reset_keeps", 32'(susp), 32'h04);
    wr_op("R8_resume", bank_addr(3'd2), hd(8'h30), OP_RESUME);
    chk("R8_resume_flag", 32'(susp), 32'd0);
    ers = '0;

    // reset in mid erase sequence
    unlock("R9_mid");
    wr_none("R9_mid", kaddr(k1(0), 0), hd(8'h80));
    wr_op("R9_mid", rnd(), hd(8'hF0), OP_RESET);
    unlock("R9_mid_after");
    wr_none("R9_mid_after", kaddr(k1(0), 0), hd(8'h10));

    // constrained random programs and erases in both bus modes
    for (int i = 0; i < 120; i++) begin
      int kind = $urandom_range(0, 2);
      byte_m = 1'($urandom);
      rd = 16'($urandom);
      if (rd[7:0] == 8'hF0) rd[7:0] = 8'h0F;
      case (kind)
        0: do_prog("R3_rand", rnd(), rd);
        1: do_erase("R4_rand_sector", 1'b0, rnd());
        default: do_erase("R4_rand_chip", 1'b1, rnd());
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule